// File: doc/BRIEF.md
# Status LED blink controller

This block drives a red and a blue status LED from a small set of configuration fields. Each LED has its own two-bit duty setting, a force-dark bit and a power-saving modulation bit. A single free-running counter on the 24.576 MHz reference clock turns those fields into blink patterns slow enough to see. A global slow-blink bit stretches both patterns to twice their period. The blue LED can also be tied to a "signal detected" input, so that it blinks only while a signal is present.

The normal blink period is 2^CNT_W clock cycles, which is about 0.17 s at the default CNT_W of 22. With the slow-blink bit set the period is 2^(CNT_W+1) cycles. Each period is split into eight equal phases, taken from the top three bits of the active counter window. The duty setting picks how many of those phases light the LED. When full duty and modulation are both selected, the LED is lit in one cycle out of every four instead of steadily. The switching is fast enough that the eye still sees a continuous glow.

Both LED outputs are registered and active high.

Top module: `led_blink_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, both LED outputs are low after that edge, and the blink counter restarts from zero.
- R2: Let `c` be the counter value, starting at 0 after reset and incrementing each cycle, and let `p` be the phase: `c[CNT_W-1:CNT_W-3]` at normal rate. Duty code 0 lights the LED in every phase, code 1 when p < 4, code 2 when p < 2, and code 3 only when p == 0.
- R3: A set force-dark bit keeps that LED low, whatever its other settings.
- R4: With duty code 0 and the modulate bit set, the LED is lit only when `c[MOD_W-1:0]` is zero, which is one cycle in four by default.
- R5: The modulate bit has no effect at duty codes 1, 2 and 3.
- R6: With `half_rate` high the phase is taken from `c[CNT_W:CNT_W-2]`, which doubles the period of both LEDs.
- R7: With `blue_follow_det` high the blue LED applies its pattern only while `det_in` is high, and is low while `det_in` is low.
- R8: With `blue_follow_det` low, `det_in` has no effect on the blue LED.
- R9: The red LED ignores both `det_in` and `blue_follow_det`.
- R10: Each output takes the value decoded from the counter value and the inputs present at the previous rising edge. A configuration change therefore shows at the outputs after exactly one edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 24.576 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| half_rate | input | 1 | Slow both blink patterns by a factor of two |
| red_duty | input | 2 | Red duty code (0 = full, 1 = 1/2, 2 = 1/4, 3 = 1/8) |
| red_off | input | 1 | Force the red LED dark |
| red_mod | input | 1 | Red power-saving modulation at full duty |
| blue_duty | input | 2 | Blue duty code (same encoding as red) |
| blue_off | input | 1 | Force the blue LED dark |
| blue_mod | input | 1 | Blue power-saving modulation at full duty |
| blue_follow_det | input | 1 | Gate the blue pattern with `det_in` |
| det_in | input | 1 | Signal-detected indication |
| red_led | output | 1 | Red LED drive, active high |
| blue_led | output | 1 | Blue LED drive, active high |

## Verification
The bench builds the block with CNT_W = 6 and MOD_W = 2. This shrinks a blink period to 64 cycles at normal rate and 128 at slow rate, so every phase of every pattern can be checked cycle by cycle. At that size the bench sweeps every duty code, force-dark and modulate setting of each LED, crossed with the rate bit, the follow bit and the detect level, over a full slow-rate period. It checks each LED at every cycle against a model derived only from the counter arithmetic. It also checks that every configuration change shows after exactly one edge.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;

  localparam int NUM_LEDS = 2;
  localparam int PHASE_W  = 3;
  localparam int LED_RED  = 0;
  localparam int LED_BLUE = 1;

  typedef enum logic [1:0] {
    DUTY_FULL    = 2'd0,
    DUTY_HALF    = 2'd1,
    DUTY_QUARTER = 2'd2,
    DUTY_EIGHTH  = 2'd3
  } duty_e;

  typedef struct packed {
    duty_e duty;
    logic  force_off;
    logic  modulate;
    logic  gate_en;
  } led_cfg_t;

endpackage

// File: rtl/blink_prescaler.sv
module blink_prescaler
  import led_blink_pkg::*;
#(
  parameter int CNT_W = 22,
  parameter int MOD_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               half_rate,
  output logic [PHASE_W-1:0] phase,
  output logic               mod_on
);

  localparam int TOP_W = CNT_W + 1;

  logic [TOP_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_q + 1'b1;
  end

  // Phase window: upper three bits of the normal or slowed period.
  always_comb begin
    if (half_rate) phase = count_q[CNT_W   -: PHASE_W];
    else           phase = count_q[CNT_W-1 -: PHASE_W];
  end

  assign mod_on = (count_q[MOD_W-1:0] == '0);

  // R1
  count_restart_chk: assert property (@(posedge clk)
    $past(rst) |-> count_q == '0);

  // R10
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> count_q == $past(count_q) + 1'b1);

endmodule

// File: rtl/led_pattern.sv
module led_pattern
  import led_blink_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  led_cfg_t           cfg,
  input  logic [PHASE_W-1:0] phase,
  input  logic               mod_on,
  input  logic               det,
  output logic               led_q
);

  logic duty_lit;
  logic lit;

  always_comb begin
    unique case (cfg.duty)
      DUTY_FULL:    duty_lit = cfg.modulate ? mod_on : 1'b1;
      DUTY_HALF:    duty_lit = (phase < 3'd4);
      DUTY_QUARTER: duty_lit = (phase < 3'd2);
      DUTY_EIGHTH:  duty_lit = (phase == 3'd0);
      default:      duty_lit = 1'b0;
    endcase
  end

  always_comb begin
    lit = duty_lit;
    if (cfg.gate_en && !det) lit = 1'b0;
    if (cfg.force_off)       lit = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) led_q <= 1'b0;
    else     led_q <= lit;
  end

  // R3
  force_dark_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && cfg.force_off) |-> !led_q);

  // R7
  gate_dark_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && cfg.gate_en && !det) |-> !led_q);

  // R2
  steady_full_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && cfg.duty == DUTY_FULL && !cfg.modulate && !cfg.force_off
          && !(cfg.gate_en && !det)) |-> led_q);

  // R2
  eighth_dark_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && cfg.duty == DUTY_EIGHTH && phase != 3'd0) |-> !led_q);

  // R4
  mod_sparse_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && cfg.duty == DUTY_FULL && cfg.modulate && !mod_on) |-> !led_q);

endmodule

// File: rtl/led_blink_ctrl.sv
module led_blink_ctrl
  import led_blink_pkg::*;
#(
  parameter int CNT_W = 22,
  parameter int MOD_W = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       half_rate,
  input  logic [1:0] red_duty,
  input  logic       red_off,
  input  logic       red_mod,
  input  logic [1:0] blue_duty,
  input  logic       blue_off,
  input  logic       blue_mod,
  input  logic       blue_follow_det,
  input  logic       det_in,
  output logic       red_led,
  output logic       blue_led
);

  logic [PHASE_W-1:0]  phase;
  logic                mod_on;
  led_cfg_t            cfg   [NUM_LEDS];
  logic [NUM_LEDS-1:0] led_q;

  blink_prescaler #(
    .CNT_W (CNT_W),
    .MOD_W (MOD_W)
  ) u_prescaler (
    .clk       (clk),
    .rst       (rst),
    .half_rate (half_rate),
    .phase     (phase),
    .mod_on    (mod_on)
  );

  always_comb begin
    cfg[LED_RED].duty       = duty_e'(red_duty);
    cfg[LED_RED].force_off  = red_off;
    cfg[LED_RED].modulate   = red_mod;
    cfg[LED_RED].gate_en    = 1'b0;
    cfg[LED_BLUE].duty      = duty_e'(blue_duty);
    cfg[LED_BLUE].force_off = blue_off;
    cfg[LED_BLUE].modulate  = blue_mod;
    cfg[LED_BLUE].gate_en   = blue_follow_det;
  end

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
    led_pattern u_pattern (
      .clk    (clk),
      .rst    (rst),
      .cfg    (cfg[i]),
      .phase  (phase),
      .mod_on (mod_on),
      .det    (det_in),
      .led_q  (led_q[i])
    );
  end

  assign red_led  = led_q[LED_RED];
  assign blue_led = led_q[LED_BLUE];

  // R1
  reset_dark_chk: assert property (@(posedge clk)
    $past(rst) |-> !red_led && !blue_led);

endmodule

// File: tb/led_blink_ctrl_tb.sv
module led_blink_ctrl_tb;

  localparam int CLK_P = 10;
  localparam int CNT_W = 6;
  localparam int MOD_W = 2;
  localparam int TOP_W = CNT_W + 1;
  localparam int SPAN  = 1 << TOP_W;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       half_rate = 1'b0;
  logic [1:0] red_duty = 2'd0;
  logic       red_off = 1'b0, red_mod = 1'b0;
  logic [1:0] blue_duty = 2'd0;
  logic       blue_off = 1'b0, blue_mod = 1'b0;
  logic       blue_follow_det = 1'b0, det_in = 1'b0;
  logic       red_led, blue_led;

  int checks = 0;
  int fails  = 0;
  logic [TOP_W-1:0] edges = '0;

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) edges <= '0;
    else     edges <= edges + 1'b1;
  end

  led_blink_ctrl #(.CNT_W(CNT_W), .MOD_W(MOD_W)) u_dut (
    .clk(clk), .rst(rst), .half_rate(half_rate),
    .red_duty(red_duty), .red_off(red_off), .red_mod(red_mod),
    .blue_duty(blue_duty), .blue_off(blue_off), .blue_mod(blue_mod),
    .blue_follow_det(blue_follow_det), .det_in(det_in),
    .red_led(red_led), .blue_led(blue_led)
  );

  function automatic logic model(input logic [TOP_W-1:0] c, input logic [1:0] d,
                                 input logic off, input logic md, input logic hr,
                                 input logic gate, input logic det);
    int p;
    logic on;
    p = hr ? int'((c >> (CNT_W-2)) & 7) : int'((c >> (CNT_W-3)) & 7);
    case (d)
      2'd0:    on = md ? ((c % (1 << MOD_W)) == 0) : 1'b1;
      2'd1:    on = (p < 4);
      2'd2:    on = (p < 2);
      default: on = (p == 0);
    endcase
    if (gate && !det) on = 1'b0;
    if (off) on = 1'b0;
    return on;
  endfunction

  function automatic string tag_for(input bit is_blue, input bit first, input logic [1:0] d,
                                    input logic off, input logic md, input logic hr);
    if (first) return "R10";
    if (off) return "R3";
    if (is_blue && blue_follow_det && !det_in) return "R7";
    if (is_blue && !blue_follow_det && det_in) return "R8";
    if (!is_blue && (blue_follow_det || det_in)) return "R9";
    if (md && d == 2'd0) return "R4";
    if (md) return "R5";
    if (hr) return "R6";
    return "R2";
  endfunction

  task automatic compare(input string tag, input logic act, input logic exp, input string who);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s led at count %0d: actual %b expected %b", tag, who, edges - 1'b1, act, exp);
    end
  endtask

  // Run one full slow-rate span under the current settings, checking both LEDs each cycle.
  task automatic run_span();
    for (int k = 0; k < SPAN; k++) begin
      logic [TOP_W-1:0] c;
      @(negedge clk);
      c = edges - 1'b1;
      compare(tag_for(1'b0, k == 0, red_duty, red_off, red_mod, half_rate), red_led,
              model(c, red_duty, red_off, red_mod, half_rate, 1'b0, det_in), "red");
      compare(tag_for(1'b1, k == 0, blue_duty, blue_off, blue_mod, half_rate), blue_led,
              model(c, blue_duty, blue_off, blue_mod, half_rate, blue_follow_det, det_in), "blue");
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: outputs dark while reset is held with lit settings on the inputs.
    red_duty = 2'd0; blue_duty = 2'd0;
    repeat (3) @(negedge clk);
    compare("R1", red_led, 1'b0, "red");
    compare("R1", blue_led, 1'b0, "blue");
    rst = 1'b0;
    // R10: the first edge after release shows the decode of count zero.
    @(negedge clk);
    compare("R10", red_led, 1'b1, "red");
    compare("R10", blue_led, 1'b1, "blue");

    // Red sweep (R2 R3 R4 R5 R6 R9), blue held at a plain pattern.
    blue_duty = 2'd1; blue_off = 1'b0; blue_mod = 1'b0;
    for (int cfg = 0; cfg < 128; cfg++) begin
      red_duty        = cfg[1:0];
      red_off         = cfg[2];
      red_mod         = cfg[3];
      half_rate       = cfg[4];
      blue_follow_det = cfg[5];
      det_in          = cfg[6];
      run_span();
    end

    // Blue sweep (R2 R3 R4 R5 R6 R7 R8), red held at a plain pattern.
    red_duty = 2'd2; red_off = 1'b0; red_mod = 1'b0;
    for (int cfg = 0; cfg < 128; cfg++) begin
      blue_duty       = cfg[1:0];
      blue_off        = cfg[2];
      blue_mod        = cfg[3];
      half_rate       = cfg[4];
      blue_follow_det = cfg[5];
      det_in          = cfg[6];
      run_span();
    end

    // R1: a mid-run reset darkens both LEDs and restarts the counter.
    red_duty = 2'd0; red_off = 1'b0; red_mod = 1'b0;
    blue_duty = 2'd0; blue_off = 1'b0; blue_mod = 1'b0;
    blue_follow_det = 1'b0; det_in = 1'b0; half_rate = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    compare("R1", red_led, 1'b0, "red");
    compare("R1", blue_led, 1'b0, "blue");
    rst = 1'b0;
    red_duty = 2'd3; blue_duty = 2'd1;
    run_span();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule